// File: doc/BRIEF.md
# Register-Launched SMBus Byte-Data Master

This block is a two-wire bus master for talking to a single external sensor. Software programs a configuration word with the enable, the target's 7-bit address, the data width, a clock divider and an option to ignore acknowledges. A single write to the command word then launches one whole register-addressed transaction: a byte-data write (one or two data bytes) or a byte-data read with the repeated start it needs.

While the transaction runs, the block drives the clock and data lines as open-drain pull-downs and samples the data line for acknowledges and read data. When the transaction ends, the command word reports the result through three bits: write pending, read valid and error. A completion flag in an interrupt status word is raised at the same time. That flag is gated by a mask to form the interrupt output and is cleared by writing a one to it.

Top module: `smb_byte_master`

## Requirements
- R1: After reset the configuration word reads 0x0007FC00 (divider field all ones, everything else 0), the command word and the interrupt status and mask read 0, `irq` is low and both lines are released.
- R2: Configuration word fields are: bit 0 enable, bit 1 width (1 = 16-bit data, 0 = 8-bit), bits 9:2 address field (7-bit address in 9:3), bits 18:10 divider, bit 22 acknowledge mask. Unused bits read 0.
- R3: A write command (bit 24 = 0) with 8-bit width sends START, address+W, register byte (command bits 23:16), data byte (bits 7:0) and STOP. The addressed sensor register receives the byte.
- R4: With 16-bit width, a write sends two data bytes, bits 15:8 first, into consecutive sensor registers.
- R5: A read command (bit 24 = 1) with 8-bit width sends START, address+W, register byte, a repeated START, then address+R, and reads one byte. The byte is returned in command bits 7:0 with bits 15:8 zero, and bit 26 (read valid) is set.
- R6: A 16-bit read fetches two bytes into bits 15:8 then 7:0. The master acknowledges the first byte and not-acknowledges the last.
- R7: Command bit 25 (write pending) is set from the launch of a write until it completes.
- R8: A missing acknowledge with the mask clear aborts the transaction with a STOP and sets command bit 27 (error). Read valid and write pending are left clear.
- R9: With the acknowledge mask set, missing acknowledges raise no error and the transaction runs to completion.
- R10: A command write while a transaction is in progress is ignored entirely.
- R11: A command write that launches clears the previous read-valid and error bits.
- R12: Completion sets interrupt status bit 0 (word 2). `irq` is that bit ANDed with mask bit 0 (word 3). Writing 1 to status bit 0 clears it, and writing 0 leaves it.
- R13: The SCL period is 4 x (divider + 1) clocks. Data changes only while SCL is low, except in START and STOP conditions.
- R14: A command write while the enable bit is clear launches no transaction and leaves the status bits unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Word index: 0 config, 1 command, 2 interrupt status, 3 interrupt mask |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| scl_low | output | 1 | Pull the clock line low when 1 |
| sda_low | output | 1 | Pull the data line low when 1 |
| sda_in | input | 1 | Sampled level of the data line |
| irq | output | 1 | Masked completion interrupt |

## Verification
A sensor model answers on the wire. The bench drives it with 8-bit and 16-bit writes, so a wrong byte order or a missing second byte shows up in the model's registers. It also drives 8-bit and 16-bit reads; counting START conditions shows whether the repeated start is present, and the model's record of the master's last acknowledge shows the final NACK. A silenced model separates error aborts from the masked case, in which the read returns all ones. Launches while busy, launches while disabled, and launches right after an error show whether status and fields are touched. The spacing of the last clock rises at two divider values checks the clock rate.

// File: rtl/smb_pkg.sv
package smb_pkg;
  localparam int CFG_EN     = 0;
  localparam int CFG_WIDE   = 1;
  localparam int CFG_SID_LO = 2;
  localparam int CFG_SID_HI = 9;
  localparam int DIV_W      = 9;
  localparam int CFG_DIV_LO = 10;
  localparam int CFG_DIV_HI = CFG_DIV_LO + DIV_W - 1;
  localparam int CFG_AMASK  = 22;
  localparam int CMD_RD     = 24;
  localparam int CMD_WPEND  = 25;
  localparam int CMD_RVALID = 26;
  localparam int CMD_ERR    = 27;

  typedef enum logic [1:0] {A_CFG = 2'd0, A_CMD = 2'd1, A_IST = 2'd2, A_IMSK = 2'd3} reg_idx_e;
  typedef enum logic [1:0] {K_START, K_TX, K_RX, K_STOP} seg_kind_e;
endpackage

// File: rtl/smb_tick.sv
module smb_tick #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic [W-1:0] div,
  output logic         tick
);
  logic [W-1:0] cnt_q, cnt_d;

  assign tick = run && (cnt_q == div);

  always_comb begin
    if (!run || tick) cnt_d = '0;
    else              cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;

  // R13: a quarter-period lasts div+1 clocks, so ticks never touch when div > 0
  assert_tick_gap_R13: assert property (@(posedge clk) disable iff (!rst_n)
    tick && (div != '0) |=> !tick)
    else $error("tick gap");
endmodule

// File: rtl/smb_engine.sv
module smb_engine import smb_pkg::*; #(
  parameter int DW = DIV_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [DW-1:0] div_i,
  input  logic          rd_i,
  input  logic          wide_i,
  input  logic          amask_i,
  input  logic [6:0]    sid_i,
  input  logic [7:0]    reg_i,
  input  logic [15:0]   wdat_i,
  input  logic          sda_in,
  output logic          busy,
  output logic          done,
  output logic          err,
  output logic [15:0]   rdata,
  output logic          scl_low,
  output logic          sda_low
);
  logic          busy_q, busy_d, err_q, err_d;
  logic          rd_q, rd_d, wide_q, wide_d, am_q, am_d;
  logic [2:0]    seg_q, seg_d, stop_idx;
  logic [3:0]    bit_q, bit_d;
  logic [1:0]    ph_q, ph_d;
  logic [6:0]    sid_q, sid_d;
  logic [7:0]    reg_q, reg_d, txb;
  logic [15:0]   wdat_q, wdat_d, rx_q, rx_d;
  logic [DW-1:0] div_q, div_d;
  logic          tick, last_rx;
  seg_kind_e     kind;

  smb_tick #(.W(DW)) u_tick (.clk(clk), .rst_n(rst_n), .run(busy_q), .div(div_q), .tick(tick));

  assign stop_idx = rd_q ? (wide_q ? 3'd7 : 3'd6) : (wide_q ? 3'd5 : 3'd4);
  assign last_rx  = (seg_q + 3'd1) == stop_idx;

  // segment sequence decode
  always_comb begin
    kind = K_STOP;
    txb  = 8'h00;
    if (rd_q) begin
      case (seg_q)
        3'd0, 3'd3: kind = K_START;
        3'd1:       begin kind = K_TX; txb = {sid_q, 1'b0}; end
        3'd2:       begin kind = K_TX; txb = reg_q; end
        3'd4:       begin kind = K_TX; txb = {sid_q, 1'b1}; end
        3'd5:       kind = K_RX;
        3'd6:       kind = wide_q ? K_RX : K_STOP;
        default:    kind = K_STOP;
      endcase
    end else begin
      case (seg_q)
        3'd0:    kind = K_START;
        3'd1:    begin kind = K_TX; txb = {sid_q, 1'b0}; end
        3'd2:    begin kind = K_TX; txb = reg_q; end
        3'd3:    begin kind = K_TX; txb = wide_q ? wdat_q[15:8] : wdat_q[7:0]; end
        3'd4:    begin kind = wide_q ? K_TX : K_STOP; txb = wdat_q[7:0]; end
        default: kind = K_STOP;
      endcase
    end
  end

  // next state
  always_comb begin
    busy_d = busy_q; err_d = err_q; rd_d = rd_q; wide_d = wide_q; am_d = am_q;
    seg_d = seg_q; bit_d = bit_q; ph_d = ph_q; sid_d = sid_q; reg_d = reg_q;
    wdat_d = wdat_q; rx_d = rx_q; div_d = div_q;
    done = 1'b0;
    if (!busy_q) begin
      if (start) begin
        busy_d = 1'b1; seg_d = '0; bit_d = '0; ph_d = '0; err_d = 1'b0; rx_d = '0;
        rd_d = rd_i; wide_d = wide_i; am_d = amask_i; sid_d = sid_i;
        reg_d = reg_i; wdat_d = wdat_i; div_d = div_i;
      end
    end else if (tick) begin
      ph_d = ph_q + 2'd1;
      if (ph_q == 2'd2) begin
        if (kind == K_TX && bit_q == 4'd8 && sda_in && !am_q) err_d = 1'b1;
        if (kind == K_RX && bit_q < 4'd8) rx_d = {rx_q[14:0], sda_in};
      end
      if (ph_q == 2'd3) begin
        unique case (kind)
          K_STOP:  begin busy_d = 1'b0; done = 1'b1; end
          K_START: seg_d = seg_q + 3'd1;
          default: begin
            if (bit_q == 4'd8) begin
              bit_d = '0;
              seg_d = err_q ? stop_idx : seg_q + 3'd1;
            end else begin
              bit_d = bit_q + 4'd1;
            end
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0; err_q <= 1'b0; rd_q <= 1'b0; wide_q <= 1'b0; am_q <= 1'b0;
      seg_q <= '0; bit_q <= '0; ph_q <= '0; sid_q <= '0; reg_q <= '0;
      wdat_q <= '0; rx_q <= '0; div_q <= '0;
    end else begin
      busy_q <= busy_d; err_q <= err_d; rd_q <= rd_d; wide_q <= wide_d; am_q <= am_d;
      seg_q <= seg_d; bit_q <= bit_d; ph_q <= ph_d; sid_q <= sid_d; reg_q <= reg_d;
      wdat_q <= wdat_d; rx_q <= rx_d; div_q <= div_d;
    end
  end

  // line drive per quarter phase
  always_comb begin
    scl_low = 1'b0;
    sda_low = 1'b0;
    if (busy_q) begin
      unique case (kind)
        K_START: begin scl_low = (ph_q == 2'd0 && seg_q != 3'd0) || ph_q == 2'd3; sda_low = ph_q[1]; end
        K_STOP:  begin scl_low = ph_q == 2'd0; sda_low = !ph_q[1]; end
        K_TX:    begin
          scl_low = ph_q == 2'd0 || ph_q == 2'd3;
          sda_low = (bit_q < 4'd8) ? !txb[3'd7 - bit_q[2:0]] : 1'b0;
        end
        K_RX:    begin scl_low = ph_q == 2'd0 || ph_q == 2'd3; sda_low = bit_q == 4'd8 && !last_rx; end
      endcase
    end
  end

  assign busy  = busy_q;
  assign err   = err_q;
  assign rdata = wide_q ? rx_q : {8'h00, rx_q[7:0]};

  // R13: inside data bits the data line holds while the clock line is high
  assert_sda_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && $past(busy_q) && (kind == K_TX || kind == K_RX) && !scl_low && $past(!scl_low)
    |-> $stable(sda_low))
    else $error("sda moved with scl high");

  assert_done_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy_q && !scl_low && !sda_low)
    else $error("lines not released after done");
endmodule

// File: rtl/smb_byte_master.sv
module smb_byte_master import smb_pkg::*; (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        scl_low,
  output logic        sda_low,
  input  logic        sda_in,
  output logic        irq
);
  logic [1:0]       rs_q;
  logic             rst_s_n;
  logic             en_q, en_d, wide_q, wide_d, am_q, am_d;
  logic [7:0]       sidf_q, sidf_d, creg_q, creg_d;
  logic [DIV_W-1:0] div_q, div_d;
  logic [15:0]      cdat_q, cdat_d;
  logic             crd_q, crd_d, wpend_q, wpend_d, rval_q, rval_d, cerr_q, cerr_d;
  logic             ist_q, ist_d, imsk_q, imsk_d;
  logic             launch, eng_busy, eng_done, eng_err;
  logic [15:0]      eng_rdata;
  reg_idx_e         ridx;

  // reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  assign rst_s_n = rs_q[1];

  assign ridx = reg_idx_e'(reg_addr);

  always_comb begin
    en_d = en_q; wide_d = wide_q; am_d = am_q; sidf_d = sidf_q; div_d = div_q;
    creg_d = creg_q; cdat_d = cdat_q; crd_d = crd_q;
    wpend_d = wpend_q; rval_d = rval_q; cerr_d = cerr_q; ist_d = ist_q; imsk_d = imsk_q;
    launch = 1'b0;
    if (reg_wr) begin
      unique case (ridx)
        A_CFG: begin
          en_d = reg_wdata[CFG_EN]; wide_d = reg_wdata[CFG_WIDE]; am_d = reg_wdata[CFG_AMASK];
          sidf_d = reg_wdata[CFG_SID_HI:CFG_SID_LO]; div_d = reg_wdata[CFG_DIV_HI:CFG_DIV_LO];
        end
        A_CMD: if (!eng_busy) begin
          cdat_d = reg_wdata[15:0]; creg_d = reg_wdata[23:16]; crd_d = reg_wdata[CMD_RD];
          if (en_q) begin
            launch = 1'b1; rval_d = 1'b0; cerr_d = 1'b0; wpend_d = !reg_wdata[CMD_RD];
          end
        end
        A_IST:  if (reg_wdata[0]) ist_d = 1'b0;
        A_IMSK: imsk_d = reg_wdata[0];
      endcase
    end
    if (eng_done) begin
      ist_d  = 1'b1;
      cerr_d = eng_err;
      if (crd_q) begin rval_d = !eng_err; cdat_d = eng_rdata; end
      else       wpend_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      en_q <= 1'b0; wide_q <= 1'b0; am_q <= 1'b0; sidf_q <= '0; div_q <= '1;
      creg_q <= '0; cdat_q <= '0; crd_q <= 1'b0;
      wpend_q <= 1'b0; rval_q <= 1'b0; cerr_q <= 1'b0; ist_q <= 1'b0; imsk_q <= 1'b0;
    end else begin
      en_q <= en_d; wide_q <= wide_d; am_q <= am_d; sidf_q <= sidf_d; div_q <= div_d;
      creg_q <= creg_d; cdat_q <= cdat_d; crd_q <= crd_d;
      wpend_q <= wpend_d; rval_q <= rval_d; cerr_q <= cerr_d; ist_q <= ist_d; imsk_q <= imsk_d;
    end
  end

  always_comb begin
    reg_rdata = '0;
    unique case (ridx)
      A_CFG: begin
        reg_rdata[CFG_EN] = en_q; reg_rdata[CFG_WIDE] = wide_q; reg_rdata[CFG_AMASK] = am_q;
        reg_rdata[CFG_SID_HI:CFG_SID_LO] = sidf_q; reg_rdata[CFG_DIV_HI:CFG_DIV_LO] = div_q;
      end
      A_CMD:  reg_rdata = {4'h0, cerr_q, rval_q, wpend_q, crd_q, creg_q, cdat_q};
      A_IST:  reg_rdata[0] = ist_q;
      A_IMSK: reg_rdata[0] = imsk_q;
    endcase
  end

  assign irq = ist_q & imsk_q;

  smb_engine #(.DW(DIV_W)) u_eng (
    .clk(clk), .rst_n(rst_s_n), .start(launch), .div_i(div_q), .rd_i(reg_wdata[CMD_RD]),
    .wide_i(wide_q), .amask_i(am_q), .sid_i(sidf_q[7:1]), .reg_i(reg_wdata[23:16]),
    .wdat_i(reg_wdata[15:0]), .sda_in(sda_in), .busy(eng_busy), .done(eng_done),
    .err(eng_err), .rdata(eng_rdata), .scl_low(scl_low), .sda_low(sda_low));

  assert_pend_drop_R7: assert property (@(posedge clk) disable iff (!rst_s_n)
    eng_done && !crd_q |=> !wpend_q)
    else $error("write pending not cleared");

  assert_status_excl_R8: assert property (@(posedge clk) disable iff (!rst_s_n)
    !(rval_q && cerr_q))
    else $error("read valid with error");

  assert_busy_ignored_R10: assert property (@(posedge clk) disable iff (!rst_s_n)
    reg_wr && ridx == A_CMD && eng_busy |=> $stable(creg_q) && $stable(crd_q))
    else $error("command accepted while busy");

  assert_irq_set_R12: assert property (@(posedge clk) disable iff (!rst_s_n)
    eng_done |=> ist_q)
    else $error("completion flag missing");
endmodule

// File: tb/smb_byte_master_test.sv
module smb_byte_master_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        scl_low, sda_low, irq;
  logic        slv_low = 1'b0;
  wire         scl_ln = !scl_low;
  wire         sda_ln = !(sda_low | slv_low);

  int nchk = 0, nfail = 0;
  longint cyc = 0;

  smb_byte_master uut (.clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .scl_low(scl_low), .sda_low(sda_low),
    .sda_in(sda_ln), .irq(irq));

  always #10 clk = !clk;
  always @(posedge clk) cyc <= cyc + 1;

  // sensor model
  localparam logic [6:0] SLV = 7'h21;
  logic [7:0] mem [256];
  logic [7:0] sh = 8'h00, outb = 8'h00, ptr = 8'h00;
  logic p_scl = 1'b1, p_sda = 1'b1, active = 1'b0, sel = 1'b0, goread = 1'b0;
  logic rdmode = 1'b0, mack = 1'b0, mute = 1'b0;
  int sb = 0, nbyte = 0, starts = 0, stops = 0, falls = 0;
  longint prev_rise = 0, last_rise = 0;

  always @(scl_ln or sda_ln) begin
    if (scl_ln && p_scl && p_sda && !sda_ln) begin
      active = 1'b1; sb = -1; nbyte = 0; rdmode = 1'b0; goread = 1'b0; starts++;
    end else if (scl_ln && p_scl && !p_sda && sda_ln) begin
      active = 1'b0; stops++;
    end else if (scl_ln && !p_scl) begin
      prev_rise = last_rise; last_rise = cyc;
      if (active) begin
        if (sb < 8) begin if (!rdmode) sh = {sh[6:0], sda_ln}; end
        else if (rdmode) mack = !sda_ln;
      end
    end else if (!scl_ln && p_scl) begin
      falls++;
      if (active) begin
        if (sb == 8) begin
          sb = 0; slv_low = 1'b0;
          if (goread) begin
            goread = 1'b0; rdmode = 1'b1; outb = mem[ptr]; ptr = ptr + 8'd1; slv_low = !outb[7];
          end else if (rdmode) begin
            if (mack) begin outb = mem[ptr]; ptr = ptr + 8'd1; slv_low = !outb[7]; end
            else rdmode = 1'b0;
          end
        end else if (sb == 7) begin
          sb = 8;
          if (rdmode) slv_low = 1'b0;
          else begin
            if (nbyte == 0) begin
              sel = (sh[7:1] == SLV) && !mute; goread = sel && sh[0]; slv_low = sel;
            end else if (sel) begin
              if (nbyte == 1) ptr = sh;
              else begin mem[ptr] = sh; ptr = ptr + 8'd1; end
              slv_low = 1'b1;
            end
            nbyte++;
          end
        end else begin
          sb++;
          if (rdmode && sb >= 0) slv_low = !outb[3'd7 - sb[2:0]];
        end
      end
    end
    p_scl = scl_ln; p_sda = sda_ln;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  function automatic logic [31:0] cfgv(input logic wide, input logic am, input int div);
    return 32'h1 | (32'(wide) << 1) | (32'(SLV) << 3) | (32'(div) << 10) | (32'(am) << 22);
  endfunction

  task automatic wait_done(input string req);
    logic [31:0] v;
    bit ok = 0;
    for (int i = 0; i < 20000; i++) begin
      rd(2'd2, v);
      if (v[0]) begin ok = 1; break; end
    end
    chk({req, " completion"}, 32'(ok), 32'd1);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(2'd0, v); chk("R1 cfg", v, 32'h0007FC00);
    rd(2'd1, v); chk("R1 cmd", v, 32'h0);
    rd(2'd2, v); chk("R1 ist", v, 32'h0);
    rd(2'd3, v); chk("R1 imsk", v, 32'h0);
    chk("R1 lines/irq", {29'h0, irq, scl_low, sda_low}, 32'h0);
  endtask

  task automatic t_cfg;
    logic [31:0] v;
    wr(2'd0, 32'hFFFF_FFFF); rd(2'd0, v); chk("R2 field mask", v, 32'h0047FFFF);
    wr(2'd0, cfgv(0, 0, 3)); rd(2'd0, v); chk("R2 readback", v, 32'h00000D09);
    wr(2'd3, 32'h1);
  endtask

  task automatic t_write8;
    logic [31:0] v;
    mem[8'h12] = 8'h00;
    wr(2'd1, 32'h0012_00A5);
    rd(2'd1, v); chk("R7 pending at launch", v[27:24], 4'b0010);
    wait_done("R3");
    chk("R3 byte stored", mem[8'h12], 8'hA5);
    rd(2'd1, v); chk("R7 pending cleared", v[27:24], 4'b0000);
    chk("R13 scl period div3", 32'(last_rise - prev_rise), 32'd16);
    chk("R12 irq high", irq, 1'b1);
    wr(2'd2, 32'h0); chk("R12 W1C zero keeps", irq, 1'b1);
    wr(2'd2, 32'h1); chk("R12 W1C clears", irq, 1'b0);
  endtask

  task automatic t_write16;
    logic [31:0] v;
    wr(2'd0, cfgv(1, 0, 3));
    wr(2'd1, 32'h0030_BEEF);
    wait_done("R4"); wr(2'd2, 32'h1);
    chk("R4 high byte first", mem[8'h30], 8'hBE);
    chk("R4 low byte next", mem[8'h31], 8'hEF);
  endtask

  task automatic t_read8;
    logic [31:0] v;
    int s0;
    wr(2'd0, cfgv(0, 0, 3));
    mem[8'h40] = 8'h5A;
    s0 = starts;
    wr(2'd1, 32'h0140_FFFF);
    wait_done("R5"); wr(2'd2, 32'h1);
    rd(2'd1, v);
    chk("R5 data/valid", {v[27:24], v[15:0]}, {4'b0101, 16'h005A});
    chk("R5 repeated start", 32'(starts - s0), 32'd2);
  endtask

  task automatic t_read16;
    logic [31:0] v;
    wr(2'd0, cfgv(1, 0, 3));
    mem[8'h50] = 8'hC3; mem[8'h51] = 8'h3C;
    wr(2'd1, 32'h0150_0000);
    wait_done("R6"); wr(2'd2, 32'h1);
    rd(2'd1, v);
    chk("R6 two bytes", {v[27:24], v[15:0]}, {4'b0101, 16'hC33C});
    chk("R6 last byte NACK", 32'(mack), 32'd0);
  endtask

  task automatic t_nack;
    logic [31:0] v;
    int p0;
    wr(2'd0, cfgv(0, 0, 3));
    mute = 1'b1; mem[8'h70] = 8'h00; p0 = stops;
    wr(2'd1, 32'h0070_0033);
    wait_done("R8"); wr(2'd2, 32'h1);
    rd(2'd1, v); chk("R8 write error", v[27:24], 4'b1000);
    chk("R8 STOP sent", 32'(stops - p0), 32'd1);
    chk("R8 nothing stored", mem[8'h70], 8'h00);
    wr(2'd1, 32'h0170_0000);
    wait_done("R8"); wr(2'd2, 32'h1);
    rd(2'd1, v); chk("R8 read error", v[27:24], 4'b1001);
    // R11: launching after the error clears the old status
    mute = 1'b0; mem[8'h71] = 8'h77;
    wr(2'd1, 32'h0171_0000);
    rd(2'd1, v); chk("R11 status cleared at launch", v[27:24], 4'b0001);
    wait_done("R11"); wr(2'd2, 32'h1);
    rd(2'd1, v); chk("R11 read ok", {v[27:24], v[15:0]}, {4'b0101, 16'h0077});
  endtask

  task automatic t_mask;
    logic [31:0] v;
    wr(2'd0, cfgv(0, 1, 1));
    mute = 1'b1;
    wr(2'd1, 32'h0020_0011);
    wait_done("R9"); wr(2'd2, 32'h1);
    rd(2'd1, v); chk("R9 masked write", v[27:24], 4'b0000);
    wr(2'd1, 32'h0120_0000);
    wait_done("R9"); wr(2'd2, 32'h1);
    rd(2'd1, v); chk("R9 masked read", {v[27:24], v[15:0]}, {4'b0101, 16'h00FF});
    chk("R13 scl period div1", 32'(last_rise - prev_rise), 32'd8);
    mute = 1'b0;
  endtask

  task automatic t_busy;
    logic [31:0] v;
    wr(2'd0, cfgv(0, 0, 3));
    mem[8'h60] = 8'h00; mem[8'h61] = 8'h00;
    wr(2'd1, 32'h0060_0011);
    wr(2'd1, 32'h0161_0022);
    rd(2'd1, v); chk("R10 fields kept", v[24:16], 9'h060);
    wait_done("R10"); wr(2'd2, 32'h1);
    chk("R10 first write done", mem[8'h60], 8'h11);
    chk("R10 second write absent", mem[8'h61], 8'h00);
  endtask

  task automatic t_irq_mask;
    logic [31:0] v;
    wr(2'd3, 32'h0);
    wr(2'd1, 32'h0062_0044);
    wait_done("R12");
    chk("R12 masked irq low", irq, 1'b0);
    wr(2'd3, 32'h1); chk("R12 unmasked irq high", irq, 1'b1);
    wr(2'd2, 32'h1);
    rd(2'd2, v); chk("R12 status cleared", v, 32'h0);
  endtask

  task automatic t_disabled;
    logic [31:0] v;
    int f0;
    wr(2'd0, cfgv(0, 0, 3) & ~32'h1);
    f0 = falls;
    wr(2'd1, 32'h0063_0055);
    repeat (300) @(negedge clk);
    chk("R14 no clocks", 32'(falls - f0), 32'd0);
    rd(2'd1, v); chk("R14 status unchanged", v[27:24], 4'b0000);
    rd(2'd2, v); chk("R14 no completion", v, 32'h0);
  endtask

  initial begin
    #(20 * 150000);
    nfail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_cfg();
    t_write8();
    t_write16();
    t_read8();
    t_read16();
    t_nack();
    t_mask();
    t_busy();
    t_irq_mask();
    t_disabled();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule